// File: doc/BRIEF.md
# Auto-Incrementing Work RAM Access Port

This block lets a bus master reach every byte of a 128 KB work RAM through a narrow register window. The master first sets a 17-bit address pointer. The pointer is loaded a byte at a time through three write-only pointer registers. The master then moves data through a single data register. Each access to the data register, whether a read or a write, moves the pointer on by one. A whole buffer can therefore be streamed without reloading the address. The pointer wraps from the top of the RAM back to address zero.

The port sits on an 8-bit register bus. Each access is a single-cycle strobe that carries an 8-bit register offset. The port drives a plain synchronous RAM interface made of an address, write data, write enable and registered read data. Read results come back one cycle after the strobe, together with a valid pulse. Reads of the pointer registers return the last byte that passed through the window, which models a floating data bus.

Top module: `wram_port`

## Requirements
- R1: A write strobe to offset 0x80 asserts `ram_we` in that same cycle, with `ram_addr` equal to the pointer and `ram_wdata` equal to the bus byte. The byte is stored at the pointer.
- R2: A read strobe to offset 0x80 returns the RAM byte at the pointer value of the strobe cycle.
- R3: After every access to offset 0x80, read or write, the pointer advances by one modulo 0x20000. From 0x1FFFF it goes to 0x00000.
- R4: A write to offset 0x81 loads pointer bits [7:0] from the bus byte and leaves bits [16:8] unchanged.
- R5: A write to offset 0x82 loads pointer bits [15:8] and leaves bits 16 and [7:0] unchanged.
- R6: A write to offset 0x83 loads pointer bit 16 from data bit 0, leaves bits [15:0] unchanged, and has no effect from data bits [7:1].
- R7: Reset clears the pointer to 0 and holds `bus_rvalid` and `ram_we` low.
- R8: A read of offset 0x81, 0x82 or 0x83 returns the last byte carried through offsets 0x80–0x83, whether written or returned, and leaves the pointer unchanged.
- R9: Accesses to offsets outside 0x80–0x83 have no effect: no RAM write, no pointer change and no read-valid pulse.
- R10: `bus_rvalid` pulses exactly one cycle after each read strobe in the window, including back-to-back reads, and `bus_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Single-cycle register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | 8 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read result pulse, one cycle after a read strobe |
| ram_addr | output | 17 | RAM address, equal to the pointer |
| ram_wdata | output | 8 | RAM write byte |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read byte, registered one cycle after `ram_addr` |

## Verification
Pointer and RAM-write effects are registered on the strobe edge, so they show on `ram_addr` and in the RAM model at the first falling edge after the strobe. Read results need one RAM register stage and are sampled at that same falling edge, where `bus_rvalid` and `bus_rdata` must already hold. The bench drives every strobe at a falling edge and checks at the next falling edge. Nothing is sampled at a rising edge. A streaming read with four consecutive strobes checks a fresh result in each following cycle.

// File: rtl/wram_port_pkg.sv
package wram_port_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_DATA_WR,
        OP_DATA_RD,
        OP_PTR_WR,
        OP_OBUS_RD
    } port_op_e;

    typedef struct packed {
        logic              pend;
        logic              from_ram;
        logic [BYTE_W-1:0] last_byte;
    } rd_state_t;

endpackage

// File: rtl/wram_port_decode.sv
module wram_port_decode
    import wram_port_pkg::*;
#(
    parameter int              OFF_W    = 8,
    parameter logic [OFF_W-1:0] BASE_OFF = 8'h80,
    parameter int              LANES    = 3
) (
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [OFF_W-1:0] bus_off,
    output port_op_e         op,
    output logic [LANES-1:0] lane_sel
);

    localparam logic [OFF_W-1:0] LAST_OFF = BASE_OFF + OFF_W'(LANES);

    logic in_win;
    logic is_data;

    assign in_win  = (bus_off >= BASE_OFF) && (bus_off <= LAST_OFF);
    assign is_data = (bus_off == BASE_OFF);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_OFF = BASE_OFF + OFF_W'(k + 1);
        assign lane_sel[k] = bus_en && bus_we && (bus_off == LANE_OFF);
    end

    always_comb begin
        op = OP_NONE;
        if (bus_en && in_win) begin
            if (is_data) begin
                op = bus_we ? OP_DATA_WR : OP_DATA_RD;
            end else begin
                op = bus_we ? OP_PTR_WR : OP_OBUS_RD;
            end
        end
    end

endmodule

// File: rtl/wram_port_ptr.sv
module wram_port_ptr
    import wram_port_pkg::*;
#(
    parameter int PTR_W = 17,
    parameter int LANES = (PTR_W + BYTE_W - 1) / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr_q
);

    logic [PTR_W-1:0] ptr_d;
    logic [PTR_W-1:0] lane_mask [LANES];
    logic [PTR_W-1:0] lane_bits [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int LO = k * BYTE_W;
        localparam int W  = ((PTR_W - LO) < BYTE_W) ? (PTR_W - LO) : BYTE_W;
        logic [PTR_W-1:0] ext;
        assign ext          = PTR_W'(wdata[W-1:0]);
        assign lane_bits[k] = ext << LO;
        assign lane_mask[k] = PTR_W'((1 << W) - 1) << LO;
    end

    always_comb begin
        ptr_d = ptr_q;
        if (step) begin
            ptr_d = ptr_q + PTR_W'(1);
        end
        for (int k = 0; k < LANES; k++) begin
            if (lane_sel[k]) begin
                ptr_d = (ptr_d & ~lane_mask[k]) | lane_bits[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

endmodule

// File: rtl/wram_port_rdpath.sv
module wram_port_rdpath
    import wram_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  port_op_e          op,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] ram_rdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              rvalid
);

    rd_state_t st_d;
    rd_state_t st_q;

    assign rvalid = st_q.pend;
    assign rdata  = st_q.from_ram ? ram_rdata : st_q.last_byte;

    always_comb begin
        st_d          = st_q;
        st_d.pend     = (op == OP_DATA_RD) || (op == OP_OBUS_RD);
        st_d.from_ram = (op == OP_DATA_RD);
        if (st_q.pend) begin
            st_d.last_byte = rdata;
        end
        if ((op == OP_DATA_WR) || (op == OP_PTR_WR)) begin
            st_d.last_byte = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wram_port.sv
module wram_port
    import wram_port_pkg::*;
#(
    parameter int               PTR_W    = 17,
    parameter int               OFF_W    = 8,
    parameter logic [OFF_W-1:0] BASE_OFF = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [PTR_W-1:0]  ram_addr,
    output logic [BYTE_W-1:0] ram_wdata,
    output logic              ram_we,
    input  logic [BYTE_W-1:0] ram_rdata
);

    localparam int LANES = (PTR_W + BYTE_W - 1) / BYTE_W;

    port_op_e         op;
    logic [LANES-1:0] lane_sel;
    logic             step;

    wram_port_decode #(
        .OFF_W    (OFF_W),
        .BASE_OFF (BASE_OFF),
        .LANES    (LANES)
    ) u_decode (
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_off  (bus_off),
        .op       (op),
        .lane_sel (lane_sel)
    );

    assign step = (op == OP_DATA_WR) || (op == OP_DATA_RD);

    wram_port_ptr #(
        .PTR_W (PTR_W),
        .LANES (LANES)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .lane_sel (lane_sel),
        .wdata    (bus_wdata),
        .ptr_q    (ram_addr)
    );

    wram_port_rdpath u_rdpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .wdata     (bus_wdata),
        .ram_rdata (ram_rdata),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

    assign ram_we    = (op == OP_DATA_WR);
    assign ram_wdata = bus_wdata;

endmodule

// File: rtl/wram_port_chk.sv
module wram_port_chk #(
    parameter int         PTR_W    = 17,
    parameter logic [7:0] BASE_OFF = 8'h80
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [7:0]       bus_off,
    input logic [7:0]       bus_wdata,
    input logic             bus_rvalid,
    input logic [PTR_W-1:0] ram_addr,
    input logic             ram_we
);

    logic in_win;
    logic data_acc;
    logic win_rd;
    logic moves_ptr;

    assign in_win    = (bus_off >= BASE_OFF) && (bus_off <= BASE_OFF + 8'd3);
    assign data_acc  = bus_en && (bus_off == BASE_OFF);
    assign win_rd    = bus_en && !bus_we && in_win;
    assign moves_ptr = data_acc || (bus_en && bus_we && in_win);

    AST_WE_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (bus_en && bus_we && bus_off == BASE_OFF)); // R1

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc |=> ram_addr == PTR_W'($past(ram_addr) + 1'b1)); // R3

    AST_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_off == BASE_OFF + 8'd1) |=>
        (ram_addr[7:0] == $past(bus_wdata) && ram_addr[PTR_W-1:8] == $past(ram_addr[PTR_W-1:8]))); // R4

    AST_MID_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_off == BASE_OFF + 8'd2) |=>
        (ram_addr[15:8] == $past(bus_wdata) && ram_addr[7:0] == $past(ram_addr[7:0]))); // R5

    AST_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_off == BASE_OFF + 8'd3) |=>
        (ram_addr[16] == $past(bus_wdata[0]) && ram_addr[15:0] == $past(ram_addr[15:0]))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !moves_ptr |=> ram_addr == $past(ram_addr)); // R9

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        win_rd |=> bus_rvalid); // R10

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !win_rd |=> !bus_rvalid); // R9

endmodule

bind wram_port wram_port_chk #(
    .PTR_W    (PTR_W),
    .BASE_OFF (BASE_OFF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_off    (bus_off),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .ram_addr   (ram_addr),
    .ram_we     (ram_we)
);

// File: tb/wram_port_bench.sv
`timescale 1ns/1ps
module wram_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_off = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [16:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic [7:0]  ram_rdata = 8'h00;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] mem [int];

    always #4 clk = ~clk;

    wram_port u_wram_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_off    (bus_off),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_we     (ram_we),
        .ram_rdata  (ram_rdata)
    );

    // Synchronous RAM model: registered read, read-before-write
    always @(posedge clk) begin
        logic [7:0] rv;
        rv = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00;
        if (ram_we) mem[int'(ram_addr)] = ram_wdata;
        ram_rdata <= rv;
    end

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] off, logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_off = off; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] off, output logic [7:0] d, output logic v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_off = off;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
        v = bus_rvalid;
    endtask

    task automatic set_ptr(logic [16:0] p);
        wr(8'h81, p[7:0]);
        wr(8'h82, p[15:8]);
        wr(8'h83, {7'd0, p[16]});
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       v;

        repeat (4) @(negedge clk);
        chk("R7 pointer", 32'(ram_addr), 32'h0);
        chk("R7 rvalid", 32'(bus_rvalid), 32'h0);
        chk("R7 we", 32'(ram_we), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 pointer after release", 32'(ram_addr), 32'h0);

        wr(8'h82, 8'hA5);
        wr(8'h83, 8'h01);
        for (int x = 0; x < 256; x++) begin
            wr(8'h81, 8'(x));
            chk("R4 low lane", 32'(ram_addr), 32'h1A500 | 32'(x));
        end
        for (int x = 0; x < 256; x++) begin
            wr(8'h82, 8'(x));
            chk("R5 mid lane", 32'(ram_addr), 32'h100FF | (32'(x) << 8));
        end
        for (int x = 0; x < 256; x++) begin
            wr(8'h83, 8'(x));
            chk("R6 top bit", 32'(ram_addr), (x % 2 == 1) ? 32'h1FFFF : 32'h0FFFF);
        end

        wr(8'h80, 8'h3C);
        chk("R3 wrap on write", 32'(ram_addr), 32'h0);
        set_ptr(17'h1FFFF);
        rd(8'h80, d, v);
        chk("R2 read at top", 32'(d), 32'h3C);
        chk("R3 wrap on read", 32'(ram_addr), 32'h0);

        set_ptr(17'h1FFF0);
        for (int i = 0; i < 32; i++) begin
            wr(8'h80, pat(i));
            chk("R3 step on write", 32'(ram_addr), (32'h1FFF0 + 32'(i) + 1) & 32'h1FFFF);
        end
        set_ptr(17'h1FFF0);
        for (int i = 0; i < 32; i++) begin
            rd(8'h80, d, v);
            chk("R10 valid", 32'(v), 32'h1);
            chk("R1 R2 readback", 32'(d), 32'(pat(i)));
            chk("R3 step on read", 32'(ram_addr), (32'h1FFF0 + 32'(i) + 1) & 32'h1FFFF);
        end

        wr(8'h81, 8'h5A);
        rd(8'h82, d, v);
        chk("R8 open bus after write", 32'(d), 32'h5A);
        chk("R10 open bus valid", 32'(v), 32'h1);
        chk("R8 pointer held", 32'(ram_addr), 32'h0005A);
        set_ptr(17'h1FFF3);
        rd(8'h80, d, v);
        chk("R2 read", 32'(d), 32'(pat(3)));
        rd(8'h83, d, v);
        chk("R8 open bus after read", 32'(d), 32'(pat(3)));
        rd(8'h81, d, v);
        chk("R8 open bus repeat", 32'(d), 32'(pat(3)));
        chk("R8 pointer held", 32'(ram_addr), 32'h1FFF4);

        wr(8'h84, 8'hEE);
        wr(8'h7F, 8'hEE);
        wr(8'h00, 8'hEE);
        chk("R9 pointer after foreign writes", 32'(ram_addr), 32'h1FFF4);
        rd(8'h84, d, v);
        chk("R9 no valid", 32'(v), 32'h0);
        chk("R9 pointer after foreign read", 32'(ram_addr), 32'h1FFF4);
        rd(8'h80, d, v);
        chk("R9 RAM untouched", 32'(d), 32'(pat(4)));

        set_ptr(17'h1FFF0);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_off = 8'h80;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R10 streaming valid", 32'(bus_rvalid), 32'h1);
            chk("R10 streaming data", 32'(bus_rdata), 32'(pat(k)));
            if (k == 3) bus_en = 1'b0;
        end
        @(negedge clk);
        chk("R10 valid drops", 32'(bus_rvalid), 32'h0);
        chk("R3 streaming pointer", 32'(ram_addr), 32'h1FFF4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule